// File: doc/BRIEF.md
# Indexed Codec Control Register Port

This block is the host-facing control port of an audio codec. The host sees four byte-wide addresses. The first holds an index pointer. The second reads and writes the internal control byte that the pointer selects. The third is a status byte that carries the pending-interrupt flag, and a write to it acknowledges the interrupt. The fourth is a programmed-I/O data slot that has no function here. Behind the pointer sits a file of 32 control bytes, each with its own reset value and write rules.

A mode bit in control byte 12 sets how many index bits the port decodes: 4 bits, reaching 16 bytes, or 5 bits, reaching all 32. Writes to the sample-rate and format byte are gated. A full write needs the mode-change-enable bit in the index pointer. A partial-enable flag in byte 24 lets through only the upper nibble. When the port accepts a format write, it emits a one-cycle strobe so that a clock generator and sample formatter elsewhere can reprogram themselves.

The playback datapath reports each finished block with a one-cycle pulse. The port then latches the interrupt and drives the interrupt request until the host clears it. A short calibration flag appears in byte 11 after the host raises mode-change-enable while an auto-calibration option is selected.

Top module: `codec_reg_if`

## Requirements
- R1: After reset, the index pointer reads 0x40 and status reads 0x00. The control bytes read back 0x88 (bytes 2–5, 18, 19), 0x80 (bytes 6, 7), 0x08 (byte 9), 0x8A (byte 12), 0xA0 (bytes 25, 26) and 0x00 (all others). `irq`, `play_en` and `fmt_wr_stb` are low.
- R2: Address 0 stores bits 6:0 of the written byte. Bit 7 always reads 0. Bit 6 is mode-change-enable.
- R3: When bit 6 of byte 12 is 0, address 1 uses only index bits 3:0. When it is 1, address 1 uses index bits 4:0. Unprotected bytes store and return the full written value.
- R4: A write to byte 12 changes only its bit 6. Its other bits keep their reset pattern 0x8A.
- R5: Writes to bytes 11, 22, 27 and 29 leave their contents unchanged.
- R6: A write to byte 8 behaves in one of three ways. With mode-change-enable set, the whole byte is stored. With it clear and bit 4 of byte 24 set, bits 7:4 are taken from the write and bits 3:0 are kept. With both clear, the write is dropped. `fmt_wr_stb` is high for the one cycle after an accepted write, and `fmt_val` already shows the new value in that cycle.
- R7: A write to byte 9 always stores bit 5 as 0. `play_en` follows bit 0 of byte 9.
- R8: Any write to address 2 clears status bit 0 and `irq` after the clock edge. It also clears bits 6:4 of byte 24.
- R9: A write to byte 24 that takes bit 4 from 1 to 0 clears status bit 0 and `irq`.
- R10: A `play_irq_set` pulse sets status bit 0, bit 4 of byte 24 and `irq` after the clock edge. If an acknowledge arrives in the same cycle, the set still takes effect.
- R11: If mode-change-enable goes from 0 to 1 while bit 3 or bit 4 of byte 9 is set, a calibration count is loaded with CAL_LOADS (default 1). Each read of byte 11 while the count is nonzero returns bit 5 set and decrements the count.
- R12: Address 3 reads 0x00, and writes to it change nothing. Status reads {7'b0, pending}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe, one cycle per access |
| host_re | input | 1 | Host read strobe, one cycle per access |
| host_addr | input | 2 | Direct address: 0 index, 1 data, 2 status, 3 PIO |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, combinational from the current state |
| play_irq_set | input | 1 | Playback block-complete pulse |
| fmt_wr_stb | output | 1 | One-cycle pulse after an accepted format write |
| fmt_val | output | 8 | Current contents of the format byte |
| play_en | output | 1 | Playback enable, bit 0 of byte 9 |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the host never raises `host_we` and `host_re` in the same cycle. They also assume a read strobe lasts exactly one cycle, because a held strobe would consume several calibration counts. The bench drives each access for a single clock with only one strobe active. It changes inputs on the falling edge, so the edge that acts on an access sees stable values. The only overlap the stimulus creates is the one the interrupt rules define: a playback pulse together with a status write.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;

  localparam int unsigned NREG     = 32;
  localparam int unsigned DW       = 8;
  localparam int unsigned IW       = $clog2(NREG);
  localparam int unsigned IX_FMT   = 8;
  localparam int unsigned IX_CFG   = 9;
  localparam int unsigned IX_ERRST = 11;
  localparam int unsigned IX_MODE  = 12;
  localparam int unsigned IX_AFS   = 24;
  localparam int unsigned MODE_BIT = 6;
  localparam int unsigned PI_BIT   = 4;
  localparam logic [DW-1:0] CAL_FLAG_MASK = 8'h20;
  localparam logic [DW-1:0] CFG_RSVD_MASK = 8'h20;

  typedef enum logic [1:0] {
    A_INDEX  = 2'd0,
    A_DATA   = 2'd1,
    A_STATUS = 2'd2,
    A_PIO    = 2'd3
  } host_addr_e;

  function automatic logic [DW-1:0] creg_reset(input int unsigned i);
    case (i)
      2, 3, 4, 5, 18, 19: return 8'h88;
      6, 7:               return 8'h80;
      9:                  return 8'h08;
      12:                 return 8'h8A;
      25, 26:             return 8'hA0;
      default:            return 8'h00;
    endcase
  endfunction

  function automatic logic creg_locked(input int unsigned i);
    return (i == 11) || (i == 22) || (i == 27) || (i == 29);
  endfunction

  function automatic logic [IW-1:0] eff_index(input logic [IW-1:0] raw, input logic wide);
    return wide ? raw : {1'b0, raw[IW-2:0]};
  endfunction

  function automatic logic [DW-1:0] fmt_merge(input logic [DW-1:0] old_v,
                                              input logic [DW-1:0] new_v,
                                              input logic full);
    return full ? new_v : {new_v[DW-1:4], old_v[3:0]};
  endfunction

endpackage

// File: rtl/codec_idx_reg.sv
module codec_idx_reg
  import codec_reg_pkg::*;
#(
  parameter int unsigned CAL_LOADS = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_wr,
  input  logic [DW-1:0] wdata,
  input  logic          cal_armed,
  input  logic          cal_rd,
  output logic [DW-2:0] idx_q,
  output logic          mce,
  output logic          cal_flag
);
  localparam int unsigned CW = $clog2(CAL_LOADS + 1);

  logic [CW-1:0] cal_cnt;
  logic          mce_rise;

  assign mce      = idx_q[MODE_BIT];
  assign mce_rise = idx_wr && !idx_q[MODE_BIT] && wdata[MODE_BIT];
  assign cal_flag = (cal_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= 7'h40;
      cal_cnt <= '0;
    end else begin
      if (idx_wr) idx_q <= wdata[DW-2:0];
      if (mce_rise && cal_armed) cal_cnt <= CW'(CAL_LOADS);
      else if (cal_rd && cal_flag) cal_cnt <= cal_cnt - 1'b1;
    end
  end

  // R11: each flagged read consumes one count
  a_r11_cal_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_rd && cal_flag && !idx_wr) |=> (cal_cnt == $past(cal_cnt) - 1'b1));

  // R11: a qualified rising edge of mode-change-enable loads the count
  a_r11_cal_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mce_rise && cal_armed) |=> (cal_cnt == CW'(CAL_LOADS)));

endmodule

// File: rtl/codec_creg_file.sv
module codec_creg_file
  import codec_reg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_wr,
  input  logic [IW-1:0] sel,
  input  logic [DW-1:0] wdata,
  input  logic          mce,
  input  logic          ack,
  input  logic          pi_set,
  output logic [DW-1:0] regs_q [NREG],
  output logic          fmt_wr_stb,
  output logic          pi_drop
);
  logic fmt_hit, fmt_acc, afs_hit;

  assign fmt_hit = data_wr && (sel == IW'(IX_FMT));
  assign fmt_acc = fmt_hit && (mce || regs_q[IX_AFS][PI_BIT]);
  assign afs_hit = data_wr && (sel == IW'(IX_AFS));
  assign pi_drop = afs_hit && regs_q[IX_AFS][PI_BIT] && !wdata[PI_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) fmt_wr_stb <= 1'b0;
    else        fmt_wr_stb <= fmt_acc;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = data_wr && (sel == IW'(g));

    if (creg_locked(g)) begin : g_ro
      assign regs_q[g] = creg_reset(g);
    end else if (g == IX_FMT) begin : g_fmt
      always_ff @(posedge clk) begin
        if (!rst_n)       regs_q[g] <= creg_reset(g);
        else if (fmt_acc) regs_q[g] <= fmt_merge(regs_q[g], wdata, mce);
      end
    end else if (g == IX_CFG) begin : g_cfg
      always_ff @(posedge clk) begin
        if (!rst_n)   regs_q[g] <= creg_reset(g);
        else if (hit) regs_q[g] <= wdata & ~CFG_RSVD_MASK;
      end
    end else if (g == IX_MODE) begin : g_mode
      always_ff @(posedge clk) begin
        if (!rst_n)   regs_q[g] <= creg_reset(g);
        else if (hit) regs_q[g][MODE_BIT] <= wdata[MODE_BIT];
      end
    end else if (g == IX_AFS) begin : g_afs
      logic [DW-1:0] nxt;
      always_comb begin
        nxt = regs_q[g];
        if (hit) nxt = wdata;
        if (ack) nxt[6:4] = 3'b000;
        if (pi_set) nxt[PI_BIT] = 1'b1;
      end
      always_ff @(posedge clk) begin
        if (!rst_n) regs_q[g] <= creg_reset(g);
        else        regs_q[g] <= nxt;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)   regs_q[g] <= creg_reset(g);
        else if (hit) regs_q[g] <= wdata;
      end
    end
  end

  // R4: fixed bits of the mode byte never move
  a_r4_mode_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    ((regs_q[IX_MODE] & 8'hBF) == 8'h8A));

  // R6: an unqualified format write leaves the byte and strobe alone
  a_r6_fmt_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_hit && !mce && !regs_q[IX_AFS][PI_BIT]) |=> ($stable(regs_q[IX_FMT]) && !fmt_wr_stb));

  // R6: partial-enable write keeps the low nibble
  a_r6_fmt_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_hit && !mce && regs_q[IX_AFS][PI_BIT]) |=>
      (regs_q[IX_FMT][3:0] == $past(regs_q[IX_FMT][3:0]) && fmt_wr_stb));

  // R7: reserved configuration bit stays zero
  a_r7_cfg_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_q[IX_CFG][5]);

  // R10: the playback pulse always leaves the pending flag set
  a_r10_pi_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pi_set |=> regs_q[IX_AFS][PI_BIT]);

endmodule

// File: rtl/codec_irq_ctrl.sv
module codec_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic clr_req,
  output logic pend_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (set_pulse) pend_q <= 1'b1;
    else if (clr_req)   pend_q <= 1'b0;
  end

  // R8 / R9: a clear without a concurrent set drops the request
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_pulse) |=> !pend_q);

  // R10: set wins over a simultaneous clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |=> pend_q);

endmodule

// File: rtl/codec_reg_if.sv
module codec_reg_if
  import codec_reg_pkg::*;
#(
  parameter int unsigned CAL_LOADS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic       host_re,
  input  logic [1:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       play_irq_set,
  output logic       fmt_wr_stb,
  output logic [7:0] fmt_val,
  output logic       play_en,
  output logic       irq
);
  logic [DW-2:0] idx_q;
  logic          mce, cal_flag, cal_rd, pi_drop, pend_q;
  logic          idx_wr, data_wr, stat_wr;
  logic [IW-1:0] sel;
  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] data_rd;

  assign idx_wr  = host_we && (host_addr == A_INDEX);
  assign data_wr = host_we && (host_addr == A_DATA);
  assign stat_wr = host_we && (host_addr == A_STATUS);
  assign sel     = eff_index(idx_q[IW-1:0], regs_q[IX_MODE][MODE_BIT]);
  assign cal_rd  = host_re && (host_addr == A_DATA) && (sel == IW'(IX_ERRST));

  codec_idx_reg #(.CAL_LOADS(CAL_LOADS)) u_idx (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr    (idx_wr),
    .wdata     (host_wdata),
    .cal_armed (regs_q[IX_CFG][3] || regs_q[IX_CFG][4]),
    .cal_rd    (cal_rd),
    .idx_q     (idx_q),
    .mce       (mce),
    .cal_flag  (cal_flag)
  );

  codec_creg_file u_file (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_wr    (data_wr),
    .sel        (sel),
    .wdata      (host_wdata),
    .mce        (mce),
    .ack        (stat_wr),
    .pi_set     (play_irq_set),
    .regs_q     (regs_q),
    .fmt_wr_stb (fmt_wr_stb),
    .pi_drop    (pi_drop)
  );

  codec_irq_ctrl u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_pulse (play_irq_set),
    .clr_req   (stat_wr || pi_drop),
    .pend_q    (pend_q)
  );

  always_comb begin
    data_rd = regs_q[sel];
    if ((sel == IW'(IX_ERRST)) && cal_flag) data_rd = data_rd | CAL_FLAG_MASK;
  end

  always_comb begin
    case (host_addr)
      A_INDEX:  host_rdata = {1'b0, idx_q};
      A_DATA:   host_rdata = data_rd;
      A_STATUS: host_rdata = {7'b0, pend_q};
      default:  host_rdata = '0;
    endcase
  end

  assign fmt_val = regs_q[IX_FMT];
  assign play_en = regs_q[IX_CFG][0];
  assign irq     = pend_q;

  // R2: the index byte never shows bit 7
  a_r2_idx_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == A_INDEX) |-> !host_rdata[7]);

  // R12: the PIO slot reads zero
  a_r12_pio_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == A_PIO) |-> (host_rdata == 8'h00));

  // R3: in narrow mode the decoded index stays below 16
  a_r3_narrow_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_q[IX_MODE][MODE_BIT] |-> !sel[IW-1]);

endmodule

// File: tb/tb_codec_reg_if.sv
module tb_codec_reg_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0, host_re = 1'b0, play_irq_set = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata, fmt_val;
  logic       fmt_wr_stb, play_en, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_regs [32];
  logic [6:0] m_idx;
  logic       m_int;
  int         m_cnt;

  always #10 clk = ~clk;

  codec_reg_if dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .play_irq_set(play_irq_set), .fmt_wr_stb(fmt_wr_stb), .fmt_val(fmt_val),
    .play_en(play_en), .irq(irq)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, got, exp);
    end
  endtask

  function automatic int m_sel();
    return m_regs[12][6] ? int'(m_idx) % 32 : int'(m_idx) % 16;
  endfunction

  function automatic void m_reset();
    for (int i = 0; i < 32; i++) m_regs[i] = 8'h00;
    for (int i = 2; i <= 5; i++) m_regs[i] = 8'h88;
    m_regs[18] = 8'h88; m_regs[19] = 8'h88;
    m_regs[6] = 8'h80;  m_regs[7] = 8'h80;
    m_regs[9] = 8'h08;  m_regs[12] = 8'h8A;
    m_regs[25] = 8'hA0; m_regs[26] = 8'hA0;
    m_idx = 7'h40; m_int = 1'b0; m_cnt = 0;
  endfunction

  function automatic bit m_write(input logic [1:0] a, input logic [7:0] v);
    int s;
    bit stb = 1'b0;
    case (a)
      2'd0: begin
        if (!m_idx[6] && v[6] && (m_regs[9][3] || m_regs[9][4])) m_cnt = 1;
        m_idx = v[6:0];
      end
      2'd1: begin
        s = m_sel();
        if (s == 8) begin
          if (m_idx[6]) begin m_regs[8] = v; stb = 1'b1; end
          else if (m_regs[24][4]) begin m_regs[8] = {v[7:4], m_regs[8][3:0]}; stb = 1'b1; end
        end else if (s == 9) m_regs[9] = {v[7:6], 1'b0, v[4:0]};
        else if (s == 12) m_regs[12][6] = v[6];
        else if (s == 24) begin
          if (m_regs[24][4] && !v[4]) m_int = 1'b0;
          m_regs[24] = v;
        end else if (s != 11 && s != 22 && s != 27 && s != 29) m_regs[s] = v;
      end
      2'd2: begin m_int = 1'b0; m_regs[24] = m_regs[24] & 8'h8F; end
      default: ;
    endcase
    return stb;
  endfunction

  function automatic logic [7:0] m_read(input logic [1:0] a);
    logic [7:0] r;
    case (a)
      2'd0: r = {1'b0, m_idx};
      2'd1: begin
        r = m_regs[m_sel()];
        if (m_sel() == 11 && m_cnt > 0) begin r = r | 8'h20; m_cnt--; end
      end
      2'd2: r = {7'b0, m_int};
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] v, input bit setp, input string tag);
    bit stb;
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = v; play_irq_set = setp;
    stb = m_write(a, v);
    if (setp) begin m_int = 1'b1; m_regs[24][4] = 1'b1; end
    @(posedge clk); #1;
    host_we = 1'b0; play_irq_set = 1'b0;
    #5;
    chk(tag, "fmt_wr_stb", fmt_wr_stb, stb);
    chk(tag, "fmt_val", fmt_val, m_regs[8]);
    chk(tag, "irq", irq, m_int);
    chk(tag, "play_en", play_en, m_regs[9][0]);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk);
    host_re = 1'b1; host_addr = a;
    #5;
    e = m_read(a);
    chk(tag, "rdata", host_rdata, e);
    @(posedge clk); #1;
    host_re = 1'b0;
  endtask

  task automatic rd_ix(input int i, input string tag);
    wr(2'd0, 8'h40 | 8'(i), 1'b0, tag);
    rd(2'd1, tag);
  endtask

  task automatic pulse(input string tag);
    @(negedge clk);
    play_irq_set = 1'b1;
    m_int = 1'b1; m_regs[24][4] = 1'b1;
    @(posedge clk); #1;
    play_irq_set = 1'b0;
    #5;
    chk(tag, "irq", irq, m_int);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    // R1: reset outputs and the reachable bytes in narrow mode
    chk("R1", "irq", irq, 0);
    chk("R1", "play_en", play_en, 0);
    chk("R1", "fmt_wr_stb", fmt_wr_stb, 0);
    rd(2'd0, "R1");
    rd(2'd2, "R1");
    for (int i = 0; i < 16; i++) rd_ix(i, "R1");
    // R4: mode byte keeps its fixed bits while switching to wide mode
    wr(2'd0, 8'h4C, 1'b0, "R4");
    wr(2'd1, 8'hFF, 1'b0, "R4");
    rd(2'd1, "R4");
    wr(2'd1, 8'h40, 1'b0, "R4");
    rd(2'd1, "R4");
    for (int i = 16; i < 32; i++) rd_ix(i, "R1");
    // R3: narrow mode folds index 0x15 onto byte 5
    wr(2'd0, 8'h4C, 1'b0, "R3");
    wr(2'd1, 8'h00, 1'b0, "R3");
    wr(2'd0, 8'h55, 1'b0, "R3");
    wr(2'd1, 8'h3C, 1'b0, "R3");
    wr(2'd0, 8'h4C, 1'b0, "R3");
    wr(2'd1, 8'h40, 1'b0, "R3");
    rd_ix(5, "R3");
    rd_ix(21, "R3");
    // R2: bit 7 of the index is not stored
    wr(2'd0, 8'hFF, 1'b0, "R2");
    rd(2'd0, "R2");
    // R3 R5 R7: sweep every byte with a pattern, then read all back
    for (int i = 0; i < 32; i++) begin
      logic [7:0] p;
      p = 8'((i * 37 + 8'h5A) & 8'hFF);
      if (i == 12) p = p | 8'h40;
      if (i == 24) p = p & 8'hEF;
      wr(2'd0, 8'h40 | 8'(i), 1'b0, "R3");
      wr(2'd1, p, 1'b0, (i == 9) ? "R7" : "R5");
    end
    for (int i = 0; i < 32; i++) rd_ix(i, "R5");
    // R7: configuration byte with all ones
    wr(2'd0, 8'h49, 1'b0, "R7");
    wr(2'd1, 8'hFF, 1'b0, "R7");
    rd(2'd1, "R7");
    wr(2'd1, 8'h00, 1'b0, "R7");
    // R6: the three format gating cases
    wr(2'd0, 8'h58, 1'b0, "R6");
    wr(2'd1, 8'h00, 1'b0, "R6");
    wr(2'd0, 8'h08, 1'b0, "R6");
    wr(2'd1, 8'hA5, 1'b0, "R6");
    wr(2'd0, 8'h18, 1'b0, "R6");
    wr(2'd1, 8'h10, 1'b0, "R6");
    wr(2'd0, 8'h08, 1'b0, "R6");
    wr(2'd1, 8'hC3, 1'b0, "R6");
    rd(2'd1, "R6");
    wr(2'd0, 8'h48, 1'b0, "R6");
    wr(2'd1, 8'h7E, 1'b0, "R6");
    rd(2'd1, "R6");
    // R10 R8: playback pulse then status acknowledge
    wr(2'd0, 8'h58, 1'b0, "R8");
    wr(2'd1, 8'h60, 1'b0, "R8");
    pulse("R10");
    rd(2'd2, "R10");
    rd(2'd1, "R10");
    wr(2'd2, 8'h00, 1'b0, "R8");
    rd(2'd2, "R8");
    rd(2'd1, "R8");
    // R9: clearing the playback flag by a byte-24 write
    pulse("R10");
    wr(2'd1, 8'h00, 1'b0, "R9");
    rd(2'd2, "R9");
    // R9: writing byte 24 with bit 4 still set keeps the request
    pulse("R10");
    wr(2'd1, 8'h10, 1'b0, "R9");
    rd(2'd2, "R9");
    wr(2'd2, 8'h00, 1'b0, "R8");
    // R10: set wins over a same-cycle acknowledge
    wr(2'd2, 8'h00, 1'b1, "R10");
    rd(2'd2, "R10");
    rd(2'd1, "R10");
    wr(2'd2, 8'h00, 1'b0, "R8");
    // R11: calibration flag after mce rises with byte 9 bit 3 set
    wr(2'd0, 8'h49, 1'b0, "R11");
    wr(2'd1, 8'h08, 1'b0, "R11");
    wr(2'd0, 8'h0B, 1'b0, "R11");
    rd(2'd1, "R11");
    wr(2'd0, 8'h4B, 1'b0, "R11");
    rd(2'd1, "R11");
    rd(2'd1, "R11");
    // R11: no flag when byte 9 bits 4:3 are clear
    wr(2'd0, 8'h49, 1'b0, "R11");
    wr(2'd1, 8'h00, 1'b0, "R11");
    wr(2'd0, 8'h0B, 1'b0, "R11");
    wr(2'd0, 8'h4B, 1'b0, "R11");
    rd(2'd1, "R11");
    // R11: bit 4 also arms the flag
    wr(2'd0, 8'h49, 1'b0, "R11");
    wr(2'd1, 8'h10, 1'b0, "R11");
    wr(2'd0, 8'h0B, 1'b0, "R11");
    wr(2'd0, 8'h4B, 1'b0, "R11");
    rd(2'd1, "R11");
    rd(2'd1, "R11");
    // R12: PIO slot ignores writes and reads zero
    wr(2'd3, 8'hFF, 1'b0, "R12");
    rd(2'd3, "R12");
    rd(2'd0, "R12");
    rd(2'd2, "R12");
    rd_ix(9, "R12");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule